// File: doc/BRIEF.md
# Guarded Hidden Configuration Register Pair

This block sits on the host register bus of a network controller. In page 0 it holds two configuration registers, at offsets 0AH and 0BH. Offset 0AH is the interface setup register: it holds the MII select, the 16-bit I/O timing option, the two LED polarity bits, the full-duplex status, the remote-DMA cache enable and the address-decode width. Offset 0BH is the link and interrupt register: it holds the link and MII change masks and status bits, the current link state, the external RMII select and a pending-interrupt flag. A plain read of either offset returns the register.

A plain write to either offset does not change the register. It goes to the low or high byte of the remote byte count. To change a configuration register, the host first reads the offset and then, with no other register access in between, writes it. Idle bus cycles between the two accesses are allowed. Each write needs a new read. An access to any other register or page in between cancels the unlock.

An EEPROM preload strobe sets the interface register, including the decode-width bit, which the host cannot write. A two-stage synchronizer samples the asynchronous link input, and each edge of it latches a status bit. The interrupt output is registered.

Top module: `hcfg_regblock`

## Requirements
- R1: A page-0 read (rd high, wr low) of offset 0AH or 0BH returns the interface or link register on `bus_rdata`, registered at the clock edge that samples the strobe.
- R2: A page-0 write to 0AH or 0BH updates the configuration register only if the last bus access before it was a page-0 read of the same offset. Each such write consumes the unlock, so a second write needs a new read.
- R3: A page-0 write to 0AH or 0BH that is not unlocked stores its data in `rbc_count[7:0]` (0AH) or `rbc_count[15:8]` (0BH), and the configuration register stays unchanged.
- R4: Any access in between cancels a pending unlock. This covers a read of another page-0 offset, any access to another page, and a read of the other configuration offset.
- R5: After reset, the interface register reads 8'h02 with bit 5 set from `duplex_in`. The link register reads 0 apart from bit 2, which follows the synchronized link. `rbc_count` and `irq` are 0.
- R6: Interface register layout: [1:0] MII select, [2] 16-bit I/O timing, [3] duplex LED polarity, [4] link LED polarity, [5] full duplex (read-only, follows `duplex_in`), [6] remote-DMA cache enable, [7] decode width (set only by the EEPROM preload). Host writes change only bits 6, 4, 3, 2, 1 and 0.
- R7: Link register layout: [0] link-change mask, [1] link-change status, [2] link state (read-only), [3] MII-change mask, [4] MII-change status, [5] RMII select, [6] interrupt pending (read-only, equals `irq`), [7] reserved (reads 0, ignores writes). A host write stores bits 0, 3 and 5. Writing 1 to bit 1 or bit 4 clears that status bit.
- R8: Each rising or falling edge of the synchronized `link_in` sets the link-change status bit. If an event and a write-1-to-clear of the same status bit fall in the same cycle, the status bit stays set.
- R9: `irq` is a register. After each clock edge it equals (link-change status AND its mask) OR (MII-change status AND its mask), taken from the register values after that edge.
- R10: A one-cycle `mii_evt` pulse sets the MII-change status bit at the next clock edge.
- R11: An `ee_load` pulse loads interface register bits 7, 6, 4, 3, 2, 1 and 0 from `ee_cfg_a`. If it falls in the same cycle as an unlocked host write, the preload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_page | input | 2 | Register page select |
| bus_addr | input | 4 | Register offset within the page |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ee_load | input | 1 | EEPROM preload strobe |
| ee_cfg_a | input | 8 | Preload value for the interface register |
| duplex_in | input | 1 | Full-duplex status from the PHY side |
| link_in | input | 1 | Asynchronous link status |
| mii_evt | input | 1 | Synchronous MII change event pulse |
| rbc_count | output | 16 | Remote byte count (high byte from 0BH, low byte from 0AH) |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can act on the same register bit in the same cycle. An unlocked write-1-to-clear can meet an MII change event. The bench drives `mii_evt` on the exact cycle the clearing write reaches the link register, then reads the register back and expects the status bit and `irq` to remain set. Another clearing write, with no event, must then drop both. The same kind of collision is built between `ee_load` and an unlocked host write to the interface register, and the preload value must be the one that survives.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

  // which configuration register holds the pending unlock
  typedef enum logic {SEL_A = 1'b0, SEL_B = 1'b1} cfg_sel_e;

  // interface register bit positions and masks
  localparam int A_DUPLEX = 5;
  localparam logic [7:0] A_RST_VAL   = 8'h02;
  localparam logic [7:0] A_HOST_MASK = 8'h5F;
  localparam logic [7:0] A_EE_MASK   = 8'hDF;

  // link register bit positions
  localparam int B_LC_MSK = 0;
  localparam int B_LC_STS = 1;
  localparam int B_MC_MSK = 3;
  localparam int B_MC_STS = 4;
  localparam int B_RMII   = 5;

  // number of latched event sources in the link register
  localparam int N_EVT = 2;

endpackage

// File: rtl/hcfg_unlock.sv
module hcfg_unlock
  import hcfg_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int ADDR_W = 4,
  parameter logic [PAGE_W-1:0] CFG_PAGE = '0,
  parameter logic [ADDR_W-1:0] OFS_A = ADDR_W'('hA),
  parameter logic [ADDR_W-1:0] OFS_B = ADDR_W'('hB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              cfg_wr_a,
  output logic              cfg_wr_b,
  output logic              rbc_wr_lo,
  output logic              rbc_wr_hi
);

  logic     armed_q;
  cfg_sel_e sel_q;
  logic     hit_a, hit_b, rd_only, access;

  assign hit_a   = (page == CFG_PAGE) && (addr == OFS_A);
  assign hit_b   = (page == CFG_PAGE) && (addr == OFS_B);
  assign rd_only = rd && !wr;
  assign access  = rd || wr;

  assign cfg_wr_a  = wr && hit_a && armed_q && (sel_q == SEL_A);
  assign cfg_wr_b  = wr && hit_b && armed_q && (sel_q == SEL_B);
  assign rbc_wr_lo = wr && hit_a && !cfg_wr_a;
  assign rbc_wr_hi = wr && hit_b && !cfg_wr_b;

  // one armed flag plus the offset it was armed for; every access rewrites it
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      sel_q   <= SEL_A;
    end else if (access) begin
      if (rd_only && (hit_a || hit_b)) begin
        armed_q <= 1'b1;
        sel_q   <= hit_b ? SEL_B : SEL_A;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_UNLOCK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_a || cfg_wr_b) |=> !armed_q); // R2

  AST_FOREIGN_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (access && !hit_a && !hit_b) |=> !(cfg_wr_a || cfg_wr_b)); // R4

endmodule

// File: rtl/hcfg_sync_edge.sv
module hcfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic edge_p
);

  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr_q[0] <= 1'b0;
          else     sr_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr_q[g] <= 1'b0;
          else     sr_q[g] <= sr_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sr_q[STAGES-1];
  end

  assign level  = sr_q[STAGES-1];
  assign edge_p = sr_q[STAGES-1] ^ prev_q;

  AST_EDGE_FOLLOWS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    edge_p |=> !$stable(prev_q)); // R8

endmodule

// File: rtl/hcfg_cfg_regs.sv
module hcfg_cfg_regs
  import hcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] wdata,
  input  logic       cfg_wr_a,
  input  logic       cfg_wr_b,
  input  logic       ee_load,
  input  logic [7:0] ee_cfg_a,
  input  logic       duplex_in,
  input  logic       link_level,
  input  logic       link_edge,
  input  logic       mii_evt,
  output logic [7:0] cfg_a,
  output logic [7:0] cfg_b,
  output logic       irq
);

  logic [7:0]       a_q, a_d;
  logic             lc_msk_q, mc_msk_q, rmii_q;
  logic             lc_msk_d, mc_msk_d, rmii_d;
  logic [N_EVT-1:0] sts_q, sts_d, evt_vec, clr_vec, msk_d_vec, msk_q_vec;
  logic             irq_q;

  // interface register: the preload takes precedence over a host write
  always_comb begin
    a_d = a_q;
    if (ee_load)       a_d = (a_q & ~A_EE_MASK)   | (ee_cfg_a & A_EE_MASK);
    else if (cfg_wr_a) a_d = (a_q & ~A_HOST_MASK) | (wdata & A_HOST_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) a_q <= A_RST_VAL;
    else     a_q <= a_d;
  end

  // bit 5 is never stored (both masks leave it out); it shows the live input
  assign cfg_a = a_q | (8'(duplex_in) << A_DUPLEX);

  // plain read/write fields of the link register
  assign lc_msk_d = cfg_wr_b ? wdata[B_LC_MSK] : lc_msk_q;
  assign mc_msk_d = cfg_wr_b ? wdata[B_MC_MSK] : mc_msk_q;
  assign rmii_d   = cfg_wr_b ? wdata[B_RMII]   : rmii_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lc_msk_q <= 1'b0;
      mc_msk_q <= 1'b0;
      rmii_q   <= 1'b0;
    end else begin
      lc_msk_q <= lc_msk_d;
      mc_msk_q <= mc_msk_d;
      rmii_q   <= rmii_d;
    end
  end

  // latched event sources: index 0 is the link change, index 1 the MII change
  assign evt_vec   = {mii_evt, link_edge};
  assign clr_vec   = {cfg_wr_b && wdata[B_MC_STS], cfg_wr_b && wdata[B_LC_STS]};
  assign msk_d_vec = {mc_msk_d, lc_msk_d};
  assign msk_q_vec = {mc_msk_q, lc_msk_q};

  generate
    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
      // a new event outranks a clear arriving in the same cycle
      assign sts_d[i] = evt_vec[i] || (sts_q[i] && !clr_vec[i]);

      always_ff @(posedge clk) begin
        if (rst) sts_q[i] <= 1'b0;
        else     sts_q[i] <= sts_d[i];
      end

      AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        evt_vec[i] |=> sts_q[i]); // R8
    end
  endgenerate

  // interrupt computed from next-state values so it lines up with the fields
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_d & msk_d_vec);
  end

  assign irq   = irq_q;
  assign cfg_b = {1'b0, irq_q, rmii_q, sts_q[1], mc_msk_q, link_level, sts_q[0], lc_msk_q};

  AST_HOST_GUARD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ee_load) && (a_q != $past(a_q))) |-> $past(cfg_wr_a)); // R2

  AST_DECW_EE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(a_q[7])) |-> $past(ee_load)); // R6

  AST_EE_WINS: assert property (@(posedge clk) disable iff (rst)
    (ee_load && cfg_wr_a) |=> (a_q[7] == $past(ee_cfg_a[7]))); // R11

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((sts_q & msk_q_vec) != '0)); // R9

endmodule

// File: rtl/hcfg_regblock.sv
module hcfg_regblock
  import hcfg_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int ADDR_W = 4,
  parameter logic [PAGE_W-1:0] CFG_PAGE = '0,
  parameter logic [ADDR_W-1:0] OFS_A = ADDR_W'('hA),
  parameter logic [ADDR_W-1:0] OFS_B = ADDR_W'('hB),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] bus_page,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ee_load,
  input  logic [7:0]        ee_cfg_a,
  input  logic              duplex_in,
  input  logic              link_in,
  input  logic              mii_evt,
  output logic [15:0]       rbc_count,
  output logic              irq
);

  logic       cfg_wr_a, cfg_wr_b, rbc_wr_lo, rbc_wr_hi;
  logic       link_level, link_edge;
  logic [7:0] cfg_a, cfg_b;
  logic [7:0] rbc_lo_q, rbc_hi_q, rdata_q;
  logic       rd_hit_a, rd_hit_b;

  hcfg_unlock #(
    .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CFG_PAGE(CFG_PAGE),
    .OFS_A(OFS_A), .OFS_B(OFS_B)
  ) u_unlock (
    .clk(clk), .rst(rst), .page(bus_page), .addr(bus_addr),
    .rd(bus_rd), .wr(bus_wr),
    .cfg_wr_a(cfg_wr_a), .cfg_wr_b(cfg_wr_b),
    .rbc_wr_lo(rbc_wr_lo), .rbc_wr_hi(rbc_wr_hi)
  );

  hcfg_sync_edge #(.STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst(rst), .din(link_in),
    .level(link_level), .edge_p(link_edge)
  );

  hcfg_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wdata(bus_wdata),
    .cfg_wr_a(cfg_wr_a), .cfg_wr_b(cfg_wr_b),
    .ee_load(ee_load), .ee_cfg_a(ee_cfg_a), .duplex_in(duplex_in),
    .link_level(link_level), .link_edge(link_edge), .mii_evt(mii_evt),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .irq(irq)
  );

  // remote byte count bytes that catch the writes which fall through
  always_ff @(posedge clk) begin
    if (rst) begin
      rbc_lo_q <= '0;
      rbc_hi_q <= '0;
    end else begin
      if (rbc_wr_lo) rbc_lo_q <= bus_wdata;
      if (rbc_wr_hi) rbc_hi_q <= bus_wdata;
    end
  end

  assign rbc_count = {rbc_hi_q, rbc_lo_q};

  // registered read path; other offsets are outside this block and read 0
  assign rd_hit_a = bus_rd && !bus_wr && (bus_page == CFG_PAGE) && (bus_addr == OFS_A);
  assign rd_hit_b = bus_rd && !bus_wr && (bus_page == CFG_PAGE) && (bus_addr == OFS_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd && !bus_wr) begin
      if (rd_hit_a)      rdata_q <= cfg_a;
      else if (rd_hit_b) rdata_q <= cfg_b;
      else               rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

  AST_RBC_GUARD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (rbc_lo_q != $past(rbc_lo_q))) |-> $past(rbc_wr_lo)); // R3

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_hit_b |=> !bus_rdata[7]); // R7

  AST_DUPLEX_READ: assert property (@(posedge clk) disable iff (rst)
    rd_hit_a |=> (bus_rdata[A_DUPLEX] == $past(duplex_in))); // R1

endmodule

// File: tb/hcfg_regblock_test.sv
module hcfg_regblock_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_page;
  logic [3:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        ee_load;
  logic [7:0]  ee_cfg_a;
  logic        duplex_in, link_in, mii_evt;
  logic [15:0] rbc_count;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [3:0] OA = 4'hA;
  localparam logic [3:0] OB = 4'hB;

  always #2 clk = ~clk;

  hcfg_regblock uut (
    .clk(clk), .rst(rst), .bus_page(bus_page), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ee_load(ee_load), .ee_cfg_a(ee_cfg_a), .duplex_in(duplex_in),
    .link_in(link_in), .mii_evt(mii_evt), .rbc_count(rbc_count), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] p, input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_page = p; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] p, input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_page = p; bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(2'd0, a, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(irq == 1'b0, "R5 irq after reset", irq, 0);
    check(rbc_count == 16'h0, "R5 rbc after reset", rbc_count, 0);
    rd(2'd0, OA, d);
    check(d == 8'h02, "R5 R1 register A reset", d, 8'h02);
    rd(2'd0, OB, d);
    check(d == 8'h00, "R5 R1 register B reset", d, 8'h00);
  endtask

  task automatic t_guarded_write();
    logic [7:0] d;
    rd(2'd0, OA, d);
    wr(2'd0, OA, 8'hFF);
    expect_reg(OA, 8'h5F, "R2 R6 unlocked write of A, bits 7 and 5 kept");
    check(rbc_count == 16'h0, "R3 unlocked write leaves rbc", rbc_count, 0);
  endtask

  task automatic t_fallthrough();
    logic [7:0] d;
    rd(2'd0, 4'h0, d);
    wr(2'd0, OA, 8'h33);
    check(rbc_count == 16'h0033, "R3 write 0A falls to rbc low", rbc_count, 16'h0033);
    expect_reg(OA, 8'h5F, "R3 register A unchanged");
    rd(2'd0, 4'h0, d);
    wr(2'd0, OB, 8'h9C);
    check(rbc_count == 16'h9C33, "R3 write 0B falls to rbc high", rbc_count, 16'h9C33);
    expect_reg(OB, 8'h00, "R3 register B unchanged");
  endtask

  task automatic t_one_shot();
    logic [7:0] d;
    rd(2'd0, OA, d);
    wr(2'd0, OA, 8'h01);
    wr(2'd0, OA, 8'h44);
    check(rbc_count == 16'h9C44, "R2 second write not unlocked", rbc_count, 16'h9C44);
    expect_reg(OA, 8'h01, "R2 only first write reached A");
  endtask

  task automatic t_cancel();
    logic [7:0] d;
    rd(2'd0, OA, d); rd(2'd0, 4'h3, d); wr(2'd0, OA, 8'h12);
    check(rbc_count[7:0] == 8'h12, "R4 other page-0 read cancels", rbc_count[7:0], 8'h12);
    rd(2'd0, OA, d); rd(2'd1, OA, d); wr(2'd0, OA, 8'h13);
    check(rbc_count[7:0] == 8'h13, "R4 other page read cancels", rbc_count[7:0], 8'h13);
    rd(2'd0, OB, d); wr(2'd0, OA, 8'h14);
    check(rbc_count[7:0] == 8'h14, "R4 read of B does not unlock A", rbc_count[7:0], 8'h14);
    rd(2'd0, OA, d); wr(2'd1, OA, 8'h55); wr(2'd0, OA, 8'h15);
    check(rbc_count[7:0] == 8'h15, "R4 other page write cancels", rbc_count[7:0], 8'h15);
    expect_reg(OA, 8'h01, "R4 register A untouched");
  endtask

  task automatic t_duplex();
    logic [7:0] d;
    duplex_in = 1'b1;
    expect_reg(OA, 8'h21, "R6 duplex bit follows input");
    rd(2'd0, OA, d);
    wr(2'd0, OA, 8'h00);
    expect_reg(OA, 8'h20, "R6 host write cannot clear duplex");
  endtask

  task automatic t_eeprom();
    logic [7:0] d;
    @(negedge clk); ee_cfg_a = 8'hC6; ee_load = 1'b1;
    @(negedge clk); ee_load = 1'b0;
    expect_reg(OA, 8'hE6, "R11 preload sets A incl decode width");
    rd(2'd0, OA, d);
    wr(2'd0, OA, 8'h00);
    expect_reg(OA, 8'hA0, "R6 decode width survives host write");
    ee_cfg_a = 8'h0B;
    rd(2'd0, OA, d);
    @(negedge clk);
    bus_page = 2'd0; bus_addr = OA; bus_wdata = 8'h50; bus_wr = 1'b1; ee_load = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ee_load = 1'b0;
    expect_reg(OA, 8'h2B, "R11 preload beats host write");
  endtask

  task automatic t_link();
    logic [7:0] d;
    rd(2'd0, OB, d); wr(2'd0, OB, 8'h01);
    expect_reg(OB, 8'h01, "R7 link mask written");
    link_in = 1'b1; wait_cyc(6);
    check(irq == 1'b1, "R9 irq on masked link rise", irq, 1);
    expect_reg(OB, 8'h47, "R8 rise latched");
    rd(2'd0, OB, d); wr(2'd0, OB, 8'h03);
    check(irq == 1'b0, "R9 irq drops with status clear", irq, 0);
    expect_reg(OB, 8'h05, "R7 write one clears status");
    link_in = 1'b0; wait_cyc(6);
    expect_reg(OB, 8'h43, "R8 fall latched");
    rd(2'd0, OB, d); wr(2'd0, OB, 8'h02);
    expect_reg(OB, 8'h00, "R7 mask and status cleared");
    link_in = 1'b1; wait_cyc(6);
    check(irq == 1'b0, "R9 masked event gives no irq", irq, 0);
    expect_reg(OB, 8'h06, "R8 status set with mask off");
    rd(2'd0, OB, d); wr(2'd0, OB, 8'h02);
    expect_reg(OB, 8'h04, "R7 status cleared again");
  endtask

  task automatic t_mii();
    logic [7:0] d;
    rd(2'd0, OB, d); wr(2'd0, OB, 8'h08);
    @(negedge clk); mii_evt = 1'b1;
    @(negedge clk); mii_evt = 1'b0;
    check(irq == 1'b1, "R10 mii event raises irq", irq, 1);
    expect_reg(OB, 8'h5C, "R10 mii status latched");
  endtask

  task automatic t_collide();
    logic [7:0] d;
    rd(2'd0, OB, d);
    @(negedge clk);
    bus_page = 2'd0; bus_addr = OB; bus_wdata = 8'h18; bus_wr = 1'b1; mii_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; mii_evt = 1'b0;
    check(irq == 1'b1, "R8 set beats clear, irq", irq, 1);
    expect_reg(OB, 8'h5C, "R8 set beats clear, status");
    rd(2'd0, OB, d); wr(2'd0, OB, 8'h18);
    check(irq == 1'b0, "R9 clear without event", irq, 0);
    expect_reg(OB, 8'h0C, "R7 mii status cleared");
    rd(2'd0, OB, d); wr(2'd0, OB, 8'hA0);
    expect_reg(OB, 8'h24, "R7 rmii set, reserved bit 7 ignored");
  endtask

  initial begin
    rst = 1'b1; bus_page = '0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; ee_load = 1'b0; ee_cfg_a = '0; duplex_in = 1'b0;
    link_in = 1'b0; mii_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_guarded_write();
    t_fallthrough();
    t_one_shot();
    t_cancel();
    t_duplex();
    t_eeprom();
    t_link();
    t_mii();
    t_collide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule